// File: doc/BRIEF.md
# Hall Sensor Pattern Event Monitor

The monitor follows a three-line Hall sensor bus from a motor. The raw lines pass through a multi-flop synchronizer. Any change in the synchronized value counts as one Hall transition, and the monitor classifies each transition against two patterns that software loads. The first is the pattern the rotor is believed to be at now. The second is the pattern it should move to next. A transition that lands on the current pattern is a correct event. A transition that lands on neither pattern is a wrong event. A transition that lands only on the expected pattern raises no flag.

A wrong event also puts the block into an idle condition. In that condition the 6-bit multi-channel output pattern register is cleared and held at zero, and every output selected for protection is driven to its own configured passive level. The condition lasts until software clears the idle flag. The three sticky flags appear in an 8-bit status byte. Software sets or clears them through one-cycle strobes. The correct-event and wrong-event set conditions each drive an interrupt pulse that can be enabled on its own.

Top module: `hall_event_monitor`

## Requirements
- R1: A change on `hall_in` is classified on the third rising clock edge after it is applied. The flags and interrupts change on that edge. An input that does not change produces no event.
- R2: On a transition, the correct-event flag (status bit 4) is set when the synchronized Hall value equals the current pattern.
- R3: On a transition, the wrong-event flag (status bit 5) is set when the value equals neither the current pattern nor the expected pattern. A value equal only to the expected pattern sets no flag.
- R4: The idle flag (status bit 6) is set by hardware on the same edge as a hardware-set wrong-event flag. It can also be set through `flag_set[2]`. It clears only through `flag_clr[2]`.
- R5: `mcp_out` shows the last value written through `mcp_wr`. It reads zero from the edge on which idle becomes 1, and writes are ignored while idle stays 1.
- R6: While idle is 1, `out_drv[i]` equals `passive_lvl[i]` for every bit with `passive_sel[i]`=1. All other bits, and all bits while idle is 0, pass `out_in[i]` through.
- R7: `irq_correct` or `irq_wrong` is a pulse, registered with the flag. It is raised for each set condition of its flag, whether from hardware or from `flag_set`, even when the flag is already 1. It is raised only when its enable input is 1.
- R8: The status byte holds correct at bit 4, wrong at bit 5 and idle at bit 6. Bits 7 and 3..0 always read 0.
- R9: When a set condition and a clear strobe reach the same flag in one cycle, the flag ends up 1.
- R10: After reset all flags, both patterns, `mcp_out` and both interrupts are 0, and `out_drv` follows `out_in`.
- R11: `flag_set` and `flag_clr` use bit 0 for correct, bit 1 for wrong and bit 2 for idle. A pattern write through `pat_wr` loads both patterns at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hall_in | input | 3 | Raw Hall sensor lines |
| pat_wr | input | 1 | Load strobe for both patterns |
| pat_cur_wdata | input | 3 | New current pattern |
| pat_exp_wdata | input | 3 | New expected pattern |
| flag_set | input | 3 | Software set strobes {idle, wrong, correct} |
| flag_clr | input | 3 | Software clear strobes {idle, wrong, correct} |
| irq_en_correct | input | 1 | Enable for the correct-event interrupt |
| irq_en_wrong | input | 1 | Enable for the wrong-event interrupt |
| mcp_wr | input | 1 | Write strobe for the multi-channel pattern |
| mcp_wdata | input | 6 | Multi-channel pattern write data |
| out_in | input | 6 | Normal output levels from the modulator |
| passive_sel | input | 6 | Outputs forced while idle |
| passive_lvl | input | 6 | Passive level for each output |
| status | output | 8 | Flag status byte |
| mcp_out | output | 6 | Multi-channel pattern register |
| out_drv | output | 6 | Gated output levels |
| irq_correct | output | 1 | Correct-event interrupt pulse |
| irq_wrong | output | 1 | Wrong-event interrupt pulse |

## Verification
Some properties are checked by assertions on every cycle. While idle is 1, the pattern register reads zero and the selected outputs sit at their passive levels. The reserved status bits stay zero. An interrupt never appears without its flag. Idle rises only together with a wrong event or a software set, and falls only after a clear strobe. Other behaviour needs the bench's scenarios: the three-edge latency, classification against the two patterns, a repeated software set pulsing an interrupt that is already set, set winning over clear, and ignored writes while idle.

// File: rtl/hall_mon_pkg.sv
package hall_mon_pkg;
    localparam int STATUS_W    = 8;
    localparam int NUM_FLAGS   = 3;
    localparam int NUM_IRQS    = 2;
    localparam int FL_CORRECT  = 0;
    localparam int FL_WRONG    = 1;
    localparam int FL_IDLE     = 2;
    localparam int ST_CORRECT  = 4;
    localparam int ST_WRONG    = 5;
    localparam int ST_IDLE     = 6;

    typedef struct packed {
        logic correct;
        logic wrong;
    } hall_class_t;
endpackage

// File: rtl/hall_edge_sync.sv
module hall_edge_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_in,
    output logic [W-1:0] sync_out,
    output logic         edge_stb
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] chain;
        logic [W-1:0]             prev;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d          = st_q;
        st_d.chain[0] = raw_in;
        for (int k = 1; k < STAGES; k++) begin
            st_d.chain[k] = st_q.chain[k-1];
        end
        st_d.prev = st_q.chain[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.chain[STAGES-1];
    assign edge_stb = (st_q.chain[STAGES-1] != st_q.prev);
endmodule

// File: rtl/hall_classifier.sv
module hall_classifier
    import hall_mon_pkg::*;
#(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         pat_wr,
    input  logic [W-1:0] pat_cur_wdata,
    input  logic [W-1:0] pat_exp_wdata,
    input  logic         edge_stb,
    input  logic [W-1:0] hall_val,
    output hall_class_t  cls
);
    typedef struct packed {
        logic [W-1:0] cur;
        logic [W-1:0] nxt;
    } st_t;

    st_t st_d, st_q;
    logic hit_cur, hit_exp;

    always_comb begin
        st_d = st_q;
        if (pat_wr) begin
            st_d.cur = pat_cur_wdata;
            st_d.nxt = pat_exp_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        hit_cur     = (hall_val == st_q.cur);
        hit_exp     = (hall_val == st_q.nxt);
        cls.correct = edge_stb & hit_cur;
        cls.wrong   = edge_stb & ~hit_cur & ~hit_exp;
    end
endmodule

// File: rtl/hall_flag_bank.sv
module hall_flag_bank #(
    parameter int NF   = 3,
    parameter int NIRQ = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NF-1:0]   hw_set,
    input  logic [NF-1:0]   sw_set,
    input  logic [NF-1:0]   sw_clr,
    input  logic [NIRQ-1:0] irq_en,
    output logic [NF-1:0]   flag_q_o,
    output logic [NF-1:0]   flag_nxt_o,
    output logic [NIRQ-1:0] irq_o
);
    typedef struct packed {
        logic [NF-1:0]   flag;
        logic [NIRQ-1:0] irq;
    } st_t;

    st_t st_d, st_q;
    logic [NF-1:0] set_any;

    assign set_any = hw_set | sw_set;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NF; i++) begin
            if (set_any[i])     st_d.flag[i] = 1'b1;
            else if (sw_clr[i]) st_d.flag[i] = 1'b0;
        end
        for (int j = 0; j < NIRQ; j++) begin
            st_d.irq[j] = irq_en[j] & set_any[j];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_q_o   = st_q.flag;
    assign flag_nxt_o = st_d.flag;
    assign irq_o      = st_q.irq;
endmodule

// File: rtl/hall_out_gate.sv
module hall_out_gate #(
    parameter int MCP_W = 6,
    parameter int OUT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle_q,
    input  logic             idle_nxt,
    input  logic             mcp_wr,
    input  logic [MCP_W-1:0] mcp_wdata,
    input  logic [OUT_W-1:0] out_in,
    input  logic [OUT_W-1:0] passive_sel,
    input  logic [OUT_W-1:0] passive_lvl,
    output logic [MCP_W-1:0] mcp_out,
    output logic [OUT_W-1:0] out_drv
);
    typedef struct packed {
        logic [MCP_W-1:0] mcp;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (idle_nxt)    st_d.mcp = '0;
        else if (mcp_wr) st_d.mcp = mcp_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mcp_out = st_q.mcp;

    for (genvar g = 0; g < OUT_W; g++) begin : g_park
        assign out_drv[g] = (idle_q & passive_sel[g]) ? passive_lvl[g] : out_in[g];
    end
endmodule

// File: rtl/hall_event_monitor.sv
module hall_event_monitor
    import hall_mon_pkg::*;
#(
    parameter int HALL_W      = 3,
    parameter int MCP_W       = 6,
    parameter int OUT_W       = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [HALL_W-1:0]    hall_in,
    input  logic                 pat_wr,
    input  logic [HALL_W-1:0]    pat_cur_wdata,
    input  logic [HALL_W-1:0]    pat_exp_wdata,
    input  logic [NUM_FLAGS-1:0] flag_set,
    input  logic [NUM_FLAGS-1:0] flag_clr,
    input  logic                 irq_en_correct,
    input  logic                 irq_en_wrong,
    input  logic                 mcp_wr,
    input  logic [MCP_W-1:0]     mcp_wdata,
    input  logic [OUT_W-1:0]     out_in,
    input  logic [OUT_W-1:0]     passive_sel,
    input  logic [OUT_W-1:0]     passive_lvl,
    output logic [STATUS_W-1:0]  status,
    output logic [MCP_W-1:0]     mcp_out,
    output logic [OUT_W-1:0]     out_drv,
    output logic                 irq_correct,
    output logic                 irq_wrong
);
    logic [HALL_W-1:0]    hall_s;
    logic                 hall_edge;
    hall_class_t          cls;
    logic [NUM_FLAGS-1:0] hw_set;
    logic [NUM_FLAGS-1:0] flags_q, flags_nxt;
    logic [NUM_IRQS-1:0]  irq_vec;

    hall_edge_sync #(.W(HALL_W), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_in(hall_in),
        .sync_out(hall_s), .edge_stb(hall_edge)
    );

    hall_classifier #(.W(HALL_W)) u_cls (
        .clk(clk), .rst_n(rst_n), .pat_wr(pat_wr),
        .pat_cur_wdata(pat_cur_wdata), .pat_exp_wdata(pat_exp_wdata),
        .edge_stb(hall_edge), .hall_val(hall_s), .cls(cls)
    );

    always_comb begin
        hw_set             = '0;
        hw_set[FL_CORRECT] = cls.correct;
        hw_set[FL_WRONG]   = cls.wrong;
        hw_set[FL_IDLE]    = cls.wrong;
    end

    hall_flag_bank #(.NF(NUM_FLAGS), .NIRQ(NUM_IRQS)) u_flags (
        .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .sw_set(flag_set),
        .sw_clr(flag_clr), .irq_en({irq_en_wrong, irq_en_correct}),
        .flag_q_o(flags_q), .flag_nxt_o(flags_nxt), .irq_o(irq_vec)
    );

    hall_out_gate #(.MCP_W(MCP_W), .OUT_W(OUT_W)) u_gate (
        .clk(clk), .rst_n(rst_n), .idle_q(flags_q[FL_IDLE]),
        .idle_nxt(flags_nxt[FL_IDLE]), .mcp_wr(mcp_wr), .mcp_wdata(mcp_wdata),
        .out_in(out_in), .passive_sel(passive_sel), .passive_lvl(passive_lvl),
        .mcp_out(mcp_out), .out_drv(out_drv)
    );

    always_comb begin
        status             = '0;
        status[ST_CORRECT] = flags_q[FL_CORRECT];
        status[ST_WRONG]   = flags_q[FL_WRONG];
        status[ST_IDLE]    = flags_q[FL_IDLE];
    end

    assign irq_correct = irq_vec[FL_CORRECT];
    assign irq_wrong   = irq_vec[FL_WRONG];
endmodule

// File: rtl/hall_event_monitor_chk.sv
module hall_event_monitor_chk #(
    parameter int MCP_W = 6,
    parameter int OUT_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic [7:0]       status,
    input logic [MCP_W-1:0] mcp_out,
    input logic [OUT_W-1:0] out_drv,
    input logic [OUT_W-1:0] passive_sel,
    input logic [OUT_W-1:0] passive_lvl,
    input logic [2:0]       flag_set,
    input logic [2:0]       flag_clr,
    input logic             irq_correct,
    input logic             irq_wrong
);
    AST_IDLE_MCP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (mcp_out == '0));                                       // R5
    AST_IDLE_PASSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        status[6] |-> (((out_drv ^ passive_lvl) & passive_sel) == '0));       // R6
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (status & 8'h8F) == 8'h00);                                           // R8
    AST_IRQ_CORRECT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_correct |-> status[4]);                                           // R7
    AST_IRQ_WRONG_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        irq_wrong |-> status[5]);                                             // R7
    AST_IDLE_RISE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[6]) |-> (status[5] || $past(flag_set[2])));              // R4
    AST_IDLE_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[6]) |-> $past(flag_clr[2] && !flag_set[2]));             // R4
endmodule

bind hall_event_monitor hall_event_monitor_chk #(.MCP_W(MCP_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .status(status), .mcp_out(mcp_out),
    .out_drv(out_drv), .passive_sel(passive_sel), .passive_lvl(passive_lvl),
    .flag_set(flag_set), .flag_clr(flag_clr),
    .irq_correct(irq_correct), .irq_wrong(irq_wrong)
);

// File: tb/hall_event_monitor_test.sv
module hall_event_monitor_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] hall_in = '0;
    logic       pat_wr = 1'b0;
    logic [2:0] pat_cur_wdata = '0, pat_exp_wdata = '0;
    logic [2:0] flag_set = '0, flag_clr = '0;
    logic       irq_en_correct = 1'b0, irq_en_wrong = 1'b0;
    logic       mcp_wr = 1'b0;
    logic [5:0] mcp_wdata = '0;
    logic [5:0] out_in = 6'h3F, passive_sel = 6'h07, passive_lvl = 6'h02;
    logic [7:0] status;
    logic [5:0] mcp_out, out_drv;
    logic       irq_correct, irq_wrong;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    hall_event_monitor uut (
        .clk(clk), .rst_n(rst_n), .hall_in(hall_in), .pat_wr(pat_wr),
        .pat_cur_wdata(pat_cur_wdata), .pat_exp_wdata(pat_exp_wdata),
        .flag_set(flag_set), .flag_clr(flag_clr),
        .irq_en_correct(irq_en_correct), .irq_en_wrong(irq_en_wrong),
        .mcp_wr(mcp_wr), .mcp_wdata(mcp_wdata), .out_in(out_in),
        .passive_sel(passive_sel), .passive_lvl(passive_lvl),
        .status(status), .mcp_out(mcp_out), .out_drv(out_drv),
        .irq_correct(irq_correct), .irq_wrong(irq_wrong)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Drive strobes for exactly one rising edge; returns at the next falling edge.
    task automatic pulse_flags(input logic [2:0] s, input logic [2:0] c);
        @(negedge clk); flag_set = s; flag_clr = c;
        @(negedge clk); flag_set = '0; flag_clr = '0;
    endtask

    task automatic write_mcp(input logic [5:0] v);
        @(negedge clk); mcp_wr = 1'b1; mcp_wdata = v;
        @(negedge clk); mcp_wr = 1'b0;
    endtask

    // Change Hall lines, sample after the third rising edge.
    task automatic hall_step(input logic [2:0] v);
        @(negedge clk); hall_in = v;
        repeat (2) @(negedge clk);
        chk("R1", "status before third edge", status, 8'h00 | (status & 8'h70));
        @(negedge clk);
    endtask

    task automatic t_reset();
        chk("R10", "status", status, 8'h00);
        chk("R10", "mcp_out", mcp_out, 6'h00);
        chk("R10", "irq_correct", irq_correct, 1'b0);
        chk("R10", "irq_wrong", irq_wrong, 1'b0);
        chk("R10", "out_drv", out_drv, 6'h3F);
    endtask

    task automatic t_load_and_no_edge();
        @(negedge clk); pat_wr = 1'b1; pat_cur_wdata = 3'd5; pat_exp_wdata = 3'd4;
        irq_en_correct = 1'b1; irq_en_wrong = 1'b1;
        @(negedge clk); pat_wr = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1", "steady input gives no event", status, 8'h00);
        chk("R1", "steady input no irq", irq_correct | irq_wrong, 1'b0);
    endtask

    task automatic t_correct();
        @(negedge clk); hall_in = 3'd5;
        repeat (2) @(negedge clk);
        chk("R1", "no flag after two edges", status, 8'h00);
        @(negedge clk);
        chk("R2", "correct flag", status, 8'h10);
        chk("R7", "irq_correct pulse", irq_correct, 1'b1);
        chk("R7", "irq_wrong quiet", irq_wrong, 1'b0);
        @(negedge clk);
        chk("R7", "irq_correct one cycle", irq_correct, 1'b0);
        chk("R1", "single event per change", status, 8'h10);
        pulse_flags(3'b000, 3'b001);
        chk("R11", "clear correct via bit0", status, 8'h00);
    endtask

    task automatic t_expected_only();
        @(negedge clk); hall_in = 3'd4;
        repeat (3) @(negedge clk);
        chk("R3", "expected match sets no flag", status, 8'h00);
        chk("R3", "expected match no irq", irq_correct | irq_wrong, 1'b0);
    endtask

    task automatic t_wrong_idle();
        write_mcp(6'h2A);
        chk("R5", "mcp written", mcp_out, 6'h2A);
        @(negedge clk); hall_in = 3'd6;
        repeat (3) @(negedge clk);
        chk("R3", "wrong flag", status[5], 1'b1);
        chk("R4", "idle with wrong", status, 8'h60);
        chk("R7", "irq_wrong pulse", irq_wrong, 1'b1);
        chk("R5", "mcp cleared on idle", mcp_out, 6'h00);
        chk("R6", "passive outputs", out_drv, 6'h3A);
        write_mcp(6'h15);
        chk("R5", "write ignored while idle", mcp_out, 6'h00);
        pulse_flags(3'b000, 3'b010);
        chk("R4", "idle survives wrong clear", status, 8'h40);
        chk("R6", "still passive", out_drv, 6'h3A);
        pulse_flags(3'b000, 3'b100);
        chk("R4", "idle cleared by bit2", status, 8'h00);
        chk("R6", "outputs released", out_drv, 6'h3F);
        chk("R5", "mcp stays zero after idle", mcp_out, 6'h00);
        write_mcp(6'h15);
        chk("R5", "write accepted after idle", mcp_out, 6'h15);
    endtask

    task automatic t_sw_set();
        pulse_flags(3'b001, 3'b000);
        chk("R7", "sw set irq", irq_correct, 1'b1);
        chk("R11", "sw set bit0 -> status bit4", status, 8'h10);
        @(negedge clk);
        chk("R7", "irq drops", irq_correct, 1'b0);
        pulse_flags(3'b001, 3'b000);
        chk("R7", "irq again while already set", irq_correct, 1'b1);
        pulse_flags(3'b010, 3'b000);
        chk("R7", "sw set wrong irq", irq_wrong, 1'b1);
        chk("R4", "sw wrong does not idle", status, 8'h30);
        chk("R5", "mcp untouched", mcp_out, 6'h15);
        pulse_flags(3'b000, 3'b011);
        irq_en_correct = 1'b0;
        pulse_flags(3'b001, 3'b000);
        chk("R7", "disabled irq silent", irq_correct, 1'b0);
        chk("R7", "flag still set when disabled", status, 8'h10);
        irq_en_correct = 1'b1;
        pulse_flags(3'b000, 3'b001);
    endtask

    task automatic t_set_vs_clear();
        pulse_flags(3'b010, 3'b010);
        chk("R9", "sw set beats clear", status, 8'h20);
        pulse_flags(3'b000, 3'b010);
        @(negedge clk); hall_in = 3'd5; flag_clr = 3'b001;
        repeat (3) @(negedge clk);
        chk("R9", "hw set beats clear", status, 8'h10);
        flag_clr = '0;
        pulse_flags(3'b000, 3'b001);
    endtask

    task automatic t_layout();
        pulse_flags(3'b111, 3'b000);
        chk("R8", "all flags layout", status, 8'h70);
        chk("R8", "reserved bits zero", status & 8'h8F, 8'h00);
        chk("R4", "sw idle clears mcp", mcp_out, 6'h00);
        pulse_flags(3'b000, 3'b111);
        chk("R8", "all cleared", status, 8'h00);
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_load_and_no_edge();
        t_correct();
        t_expected_only();
        t_wrong_idle();
        t_sw_set();
        t_set_vs_clear();
        t_layout();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule